// File: doc/BRIEF.md
# Six-Step Motor Bridge Driver with Overcurrent Recovery Pulse

This block drives the three half-bridges of a brushless DC motor with two-quadrant, non-complementary control. Each phase has two lines: a PWM line and an active-low reset line. In each commutation step one phase switches at the commanded duty cycle. A second phase carries the return current, with its PWM line low and its reset line released, so that its low-side switch conducts. The third phase floats because its reset line is held asserted.

A half-bridge whose PWM input sits at a constant level through a cycle-by-cycle overcurrent event turns off. It stays off until that input changes, and it reports no fault when this happens. For this reason the block does not wait for a fault. In every PWM period it raises the return phase's PWM line for a short programmable pulse in the final cycles before the counter wraps. It also clips the switching phase's on-time so that the on-time ends before that pulse window begins.

The commutation step, direction, duty, period and pulse width are sampled only at period boundaries, so the outputs never change shape in the middle of a period. The pulse width is given in nanoseconds. It is limited to the range 50 to 100 ns and converted to clock cycles inside the block.

Top module: `bldc_sixstep_pwm`

## Requirements
- R1: While rst_n is low, all six output lines are 0 (all phases floating, all PWM lines low).
- R2: If enable is sampled low at a clock edge, all PWM lines and all reset lines are 0 after that edge. If enable is then sampled high, the outputs of period count 0 appear after the next edge.
- R3: Phases are indexed A=bit 0, B=bit 1, C=bit 2. With dir=0, the (switching, return) pair for each step is: step 0 (A,B), step 1 (A,C), step 2 (B,C), step 3 (B,A), step 4 (C,A), step 5 (C,B). With dir=1 the two roles swap. The remaining phase floats.
- R4: The switching phase has reset high. Its PWM line is high at period count c when c < duty and c < window start, and low otherwise.
- R5: The return phase has reset high. Its PWM line is low outside the recovery window.
- R6: The floating phase has reset low and PWM low.
- R7: The return phase's PWM line is high for the last N counts of every period, where N = ceil(width_ns / CLK_NS) and the window start is max(0, period+1-N).
- R8: A requested pulse width below 50 ns is treated as 50 ns, and one above 100 ns is treated as 100 ns.
- R9: The switching PWM never overlaps the recovery pulse. At most one PWM line is high in any cycle, even when duty exceeds the period.
- R10: Changes to step, dir, duty, period or pulse width take effect only from the next period's count 0.
- R11: Step codes 6 and 7 float all three phases for that period (all lines 0).
- R12: A period lasts period_in+1 clock cycles, and the counter runs 0 to period_in before it wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 0 forces every phase off |
| step_in | input | 3 | Commutation step, 0 to 5 valid |
| dir_in | input | 1 | Rotation direction, swaps switching and return phases |
| duty_in | input | 16 | Switching on-time in clock cycles per period |
| period_in | input | 16 | Last count value of a period |
| pulse_ns_in | input | 8 | Recovery pulse width in nanoseconds |
| ph_pwm | output | 3 | PWM line for each phase, index 0 = A |
| ph_rstn | output | 3 | Active-low reset line for each phase, 0 = floating |

## Verification
Every output is a register that is computed from the count and settings that take effect at that same edge. The edge that first samples enable high therefore shows count 0, and count c appears c edges later. A disable shows up after exactly one edge. Settings changed partway through a period first appear at the edge that starts the next count 0. The bench changes inputs on falling edges and compares every cycle at the falling edge against a cycle-indexed model. That model keeps counting across chained periods, so both the wrap after period_in+1 cycles and the delayed adoption of new settings are checked cycle for cycle.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
    localparam int CNT_W = 16;
    localparam int WIN_W = 8;
    localparam int NPH   = 3;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic [WIN_W-1:0] win;
        logic [2:0]       step;
        logic             dir;
        logic [NPH-1:0]   pwm;
        logic [NPH-1:0]   rstn;
    } bldc_state_t;
endpackage

// File: rtl/bldc_comm_decode.sv
module bldc_comm_decode
    import bldc_pkg::*;
(
    input  logic [2:0]     step,
    input  logic           dir,
    output logic [NPH-1:0] sw_oh,
    output logic [NPH-1:0] ret_oh,
    output logic           valid
);
    logic [NPH-1:0] fwd_sw, fwd_ret;

    always_comb begin
        valid = 1'b1;
        unique case (step)
            3'd0: begin fwd_sw = 3'b001; fwd_ret = 3'b010; end
            3'd1: begin fwd_sw = 3'b001; fwd_ret = 3'b100; end
            3'd2: begin fwd_sw = 3'b010; fwd_ret = 3'b100; end
            3'd3: begin fwd_sw = 3'b010; fwd_ret = 3'b001; end
            3'd4: begin fwd_sw = 3'b100; fwd_ret = 3'b001; end
            3'd5: begin fwd_sw = 3'b100; fwd_ret = 3'b010; end
            default: begin fwd_sw = '0; fwd_ret = '0; valid = 1'b0; end
        endcase
        sw_oh  = dir ? fwd_ret : fwd_sw;
        ret_oh = dir ? fwd_sw  : fwd_ret;
    end
endmodule

// File: rtl/bldc_pulse_conv.sv
module bldc_pulse_conv
    import bldc_pkg::*;
#(
    parameter int CLK_NS = 8,
    parameter int MIN_NS = 50,
    parameter int MAX_NS = 100,
    parameter int NS_W   = 8
) (
    input  logic [NS_W-1:0]  ns_in,
    output logic [WIN_W-1:0] cycles
);
    localparam int SUM_W = NS_W + 1;

    logic [NS_W-1:0]  ns_lim;
    logic [SUM_W-1:0] rounded;

    always_comb begin
        if (ns_in < NS_W'(MIN_NS))      ns_lim = NS_W'(MIN_NS);
        else if (ns_in > NS_W'(MAX_NS)) ns_lim = NS_W'(MAX_NS);
        else                            ns_lim = ns_in;
        rounded = {1'b0, ns_lim} + SUM_W'(CLK_NS - 1);
        cycles  = WIN_W'(rounded / SUM_W'(CLK_NS));
    end
endmodule

// File: rtl/bldc_phase_gate.sv
module bldc_phase_gate (
    input  logic active,
    input  logic is_sw,
    input  logic is_ret,
    input  logic sw_on,
    input  logic win_on,
    output logic pwm,
    output logic rstn
);
    always_comb begin
        pwm  = active & ((is_sw & sw_on) | (is_ret & win_on));
        rstn = active & (is_sw | is_ret);
    end
endmodule

// File: rtl/bldc_sixstep_pwm.sv
module bldc_sixstep_pwm
    import bldc_pkg::*;
#(
    parameter int CLK_NS = 8,
    parameter int MIN_NS = 50,
    parameter int MAX_NS = 100,
    parameter int NS_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [2:0]       step_in,
    input  logic             dir_in,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [CNT_W-1:0] period_in,
    input  logic [NS_W-1:0]  pulse_ns_in,
    output logic [NPH-1:0]   ph_pwm,
    output logic [NPH-1:0]   ph_rstn
);
    localparam int SPAN_W = CNT_W + 1;

    bldc_state_t st_q, st_d;

    logic             at_end, load;
    logic [CNT_W-1:0] cnt_n, per_n, duty_n;
    logic [WIN_W-1:0] win_n, win_conv;
    logic [2:0]       step_n;
    logic             dir_n;
    logic [SPAN_W-1:0] span, wstart;
    logic             sw_on, win_on, valid, active;
    logic [NPH-1:0]   sw_oh, ret_oh, gate_pwm, gate_rstn;

    // period boundary: settings are sampled only here or while disabled
    assign at_end = (st_q.cnt == st_q.per);
    assign load   = !enable || at_end;

    assign cnt_n  = !enable ? period_in : (at_end ? '0 : st_q.cnt + 1'b1);
    assign per_n  = load ? period_in   : st_q.per;
    assign duty_n = load ? duty_in     : st_q.duty;
    assign win_n  = load ? win_conv    : st_q.win;
    assign step_n = load ? step_in     : st_q.step;
    assign dir_n  = load ? dir_in      : st_q.dir;

    bldc_pulse_conv #(
        .CLK_NS(CLK_NS), .MIN_NS(MIN_NS), .MAX_NS(MAX_NS), .NS_W(NS_W)
    ) u_conv (
        .ns_in  (pulse_ns_in),
        .cycles (win_conv)
    );

    bldc_comm_decode u_dec (
        .step   (step_n),
        .dir    (dir_n),
        .sw_oh  (sw_oh),
        .ret_oh (ret_oh),
        .valid  (valid)
    );

    // recovery window occupies the final win_n counts of the period
    always_comb begin
        span   = {1'b0, per_n} + 1'b1;
        wstart = (span > SPAN_W'(win_n)) ? span - SPAN_W'(win_n) : '0;
        win_on = ({1'b0, cnt_n} >= wstart);
        sw_on  = ({1'b0, cnt_n} < wstart) && (cnt_n < duty_n);
        active = enable && valid;
    end

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        bldc_phase_gate u_gate (
            .active (active),
            .is_sw  (sw_oh[p]),
            .is_ret (ret_oh[p]),
            .sw_on  (sw_on),
            .win_on (win_on),
            .pwm    (gate_pwm[p]),
            .rstn   (gate_rstn[p])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = cnt_n;
        st_d.per  = per_n;
        st_d.duty = duty_n;
        st_d.win  = win_n;
        st_d.step = step_n;
        st_d.dir  = dir_n;
        st_d.pwm  = gate_pwm;
        st_d.rstn = gate_rstn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ph_pwm  = st_q.pwm;
    assign ph_rstn = st_q.rstn;
endmodule

// File: rtl/bldc_sixstep_pwm_chk.sv
module bldc_sixstep_pwm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic [2:0] ph_pwm,
    input logic [2:0] ph_rstn
);
    // R1: outputs quiet while reset is held
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (ph_pwm == 3'b000 && ph_rstn == 3'b000));

    // R2: a low enable clears every line after one edge
    a_r2_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (ph_pwm == 3'b000 && ph_rstn == 3'b000));

    // R6: a floating phase never carries a PWM pulse
    a_r6_float_pwm_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_pwm & ~ph_rstn) == 3'b000);

    // R9: switching pulse and recovery pulse never overlap
    a_r9_single_pwm: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ph_pwm) <= 1);

    // R3: either all phases float or exactly two are active
    a_r3_two_active: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ph_rstn) == 0) || ($countones(ph_rstn) == 2));
endmodule

bind bldc_sixstep_pwm bldc_sixstep_pwm_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .ph_pwm  (ph_pwm),
    .ph_rstn (ph_rstn)
);

// File: tb/sim_bldc_sixstep_pwm.sv
module sim_bldc_sixstep_pwm;
    localparam int CLK_NS_TB = 8;

    typedef struct {
        int step;
        int dir;
        int duty;
        int per;
        int ns;
    } cfg_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [2:0]  step_in = '0;
    logic        dir_in = 1'b0;
    logic [15:0] duty_in = '0;
    logic [15:0] period_in = '0;
    logic [7:0]  pulse_ns_in = '0;
    logic [2:0]  ph_pwm, ph_rstn;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bldc_sixstep_pwm u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .step_in(step_in),
        .dir_in(dir_in), .duty_in(duty_in), .period_in(period_in),
        .pulse_ns_in(pulse_ns_in), .ph_pwm(ph_pwm), .ph_rstn(ph_rstn)
    );

    function automatic logic [5:0] model(cfg_t s, int c);
        int sw_t[6]  = '{0, 0, 1, 1, 2, 2};
        int ret_t[6] = '{1, 2, 2, 0, 0, 1};
        int nsc, n, ws, d, r, t;
        logic [2:0] p, q;
        p = '0; q = '0;
        if (s.step > 5) return 6'b0;
        nsc = (s.ns < 50) ? 50 : ((s.ns > 100) ? 100 : s.ns);
        n  = (nsc + CLK_NS_TB - 1) / CLK_NS_TB;
        ws = s.per + 1 - n;
        if (ws < 0) ws = 0;
        d = sw_t[s.step]; r = ret_t[s.step];
        if (s.dir != 0) begin t = d; d = r; r = t; end
        p[d] = (c < s.duty) && (c < ws);
        p[r] = (c >= ws);
        q[d] = 1'b1; q[r] = 1'b1;
        return {p, q};
    endfunction

    task automatic check(logic [5:0] exp, string req, int c);
        checks++;
        if ({ph_pwm, ph_rstn} !== exp) begin
            errors++;
            $display("FAIL %s cnt=%0d got pwm=%b rstn=%b exp pwm=%b rstn=%b",
                     req, c, ph_pwm, ph_rstn, exp[5:3], exp[2:0]);
        end
    endtask

    task automatic apply(cfg_t s);
        step_in = 3'(s.step); dir_in = s.dir[0];
        duty_in = 16'(s.duty); period_in = 16'(s.per); pulse_ns_in = 8'(s.ns);
    endtask

    task automatic observe(cfg_t s, int from, int to, string req);
        for (int c = from; c <= to; c++) begin
            @(negedge clk);
            check(model(s, c), req, c);
        end
    endtask

    task automatic stop_run();
        enable = 1'b0;
        @(negedge clk);
        check(6'b0, "R2 stop", 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) begin @(negedge clk); check(6'b0, "R1 in reset", 0); end
        rst_n = 1'b1;
        @(negedge clk);
        check(6'b0, "R1 after release, disabled", 0);
    endtask

    task automatic t_basic();
        cfg_t s = '{0, 0, 20, 49, 50};
        apply(s); enable = 1'b1;
        observe(s, 0, 49, "R3 R4 R5 R6 R7 first period");
        observe(s, 0, 49, "R12 wrap second period");
        stop_run();
    endtask

    task automatic t_table();
        cfg_t s;
        enable = 1'b1;
        for (int d = 0; d < 2; d++)
            for (int st = 0; st < 6; st++) begin
                s = '{st, d, 5, 19, 60};
                apply(s);
                observe(s, 0, 19, "R3 commutation table");
            end
        stop_run();
    endtask

    task automatic t_invalid();
        cfg_t s;
        enable = 1'b1;
        for (int st = 6; st < 8; st++) begin
            s = '{st, 0, 5, 9, 50};
            apply(s);
            observe(s, 0, 9, "R11 invalid step floats");
        end
        stop_run();
    endtask

    task automatic t_clamp();
        cfg_t s = '{2, 1, 1000, 29, 20};
        apply(s); enable = 1'b1;
        observe(s, 0, 29, "R8 low clamp R9 clip");
        s = '{4, 0, 1000, 29, 200};
        apply(s);
        observe(s, 0, 29, "R8 high clamp R9 clip");
        stop_run();
    endtask

    task automatic t_tiny();
        cfg_t s = '{1, 0, 3, 3, 50};
        apply(s); enable = 1'b1;
        observe(s, 0, 3, "R7 window covers whole period");
        observe(s, 0, 3, "R7 R12 tiny period wrap");
        stop_run();
    endtask

    task automatic t_midchange();
        cfg_t a = '{0, 0, 12, 24, 56};
        cfg_t b = '{5, 1, 4, 14, 96};
        apply(a); enable = 1'b1;
        observe(a, 0, 6, "R10 before change");
        apply(b);
        observe(a, 7, 24, "R10 old settings hold");
        observe(b, 0, 14, "R10 new settings at boundary");
        stop_run();
    endtask

    task automatic t_enable_drop();
        cfg_t s = '{3, 0, 9, 19, 70};
        apply(s); enable = 1'b1;
        observe(s, 0, 5, "R2 running");
        enable = 1'b0;
        repeat (3) begin @(negedge clk); check(6'b0, "R2 forced off", 0); end
        enable = 1'b1;
        observe(s, 0, 19, "R2 restart at count 0");
        stop_run();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_table();
        t_invalid();
        t_clamp();
        t_tiny();
        t_midchange();
        t_enable_drop();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule